// File: doc/BRIEF.md
# Speculative memory request shadow tracker

This block keeps the bookkeeping for a small, fixed pool of memory requests that are still in flight. Requests are issued in a given order and keep that order until they are released. Each request first asks the target whether the access could be carried out, without any promise to do it. When the target says it could, the request is in an agreed state and must either finish or be flushed. A request finishes only after it has been given the go-ahead to commit.

Each slot has a single shadow bit. A slot stays under a shadow while any older request is still open, or while its own go-ahead is missing. The block grants commit to at most one request per cycle. That request is always the oldest live one. After the grant, the slot waits for a completion acknowledge, and only then does the next request become the oldest.

Cancelling a request removes it and, in the same cycle, every request issued after it. This is how a mispredicted or squashed access is undone without any rollback.

Top module: `spec_shadow_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it: no slot is live, no shadow is raised, alloc_ready is 1 and grant_valid is 0.
- R2: Slots are handed out in circular index order after the youngest live slot (alloc_slot = oldest index + live count, modulo N_SLOTS), one per cycle when alloc_valid and alloc_ready are both 1. alloc_ready is 0 exactly when all N_SLOTS slots are live, and an allocation attempt is then refused.
- R3: A new slot starts in the offer phase and enters the exchange phase on a cycle where its tgt_ready bit is 1. A slot still in the offer phase is never granted, even when it is the oldest and has its go-ahead.
- R4: shadow[i] is 1 for every live slot except the oldest live slot once its go-ahead has been recorded. At most one live slot is ever unshadowed. A go_ahead bit is recorded in either the offer or the exchange phase.
- R5: grant_valid is 1 exactly when the oldest live slot is in the exchange phase with its go-ahead recorded, and grant_slot then names that slot. A younger slot that is ready and has its go-ahead is never granted ahead of an older live slot.
- R6: A granted slot stays live after its grant until the first cycle in which cmpl_ack is 1. It is freed on that edge, and the next oldest slot becomes the oldest. A cmpl_ack with no granted slot waiting has no effect. Each slot is granted once.
- R7: cancel[i] on a live slot i frees slot i and every younger live slot on the same clock edge. Older slots are unaffected. With several cancel bits, the oldest cancelled slot decides.
- R8: A slot being granted in the current cycle, or waiting for its acknowledge, ignores cancel. A cancel of a younger slot in the grant cycle still flushes that slot and everything younger, and the granted slot still completes.
- R9: tgt_ready, go_ahead and cancel bits for slots that are not live have no effect. In particular, a slot allocated after a go_ahead on its free index starts shadowed.
- R10: An allocation in the same cycle as a cancel takes the index of the oldest flushed slot. If the whole pool is flushed, it takes the index of the former oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; frees all slots |
| alloc_valid | input | 1 | Request to allocate a new slot this cycle |
| alloc_ready | output | 1 | A slot is free; allocation is accepted |
| alloc_slot | output | $clog2(N_SLOTS) | Index the allocation takes this cycle |
| tgt_ready | input | N_SLOTS | Per slot: target accepted the offer |
| go_ahead | input | N_SLOTS | Per slot: request may commit |
| cancel | input | N_SLOTS | Per slot: flush this and all younger requests |
| cmpl_ack | input | 1 | The granted request has completed |
| grant_valid | output | 1 | Commit is granted this cycle |
| grant_slot | output | $clog2(N_SLOTS) | Index of the granted slot |
| shadow | output | N_SLOTS | Per slot shadow bit |
| slot_live | output | N_SLOTS | Per slot: slot holds a request |

## Verification
The bound checker watches, on every cycle, that a grant goes only to the oldest live slot and only when that slot is unshadowed. It also checks that at most one live slot is free of shadow, that a full pool refuses allocation, that a grant never repeats on the following cycle, that a granted slot survives into its wait for acknowledge, and that reset empties the pool. Other behaviour spans several cycles and follows the scenario of each test. This covers the flush of all younger slots by a cancel, the immunity of a granted slot, and the reuse of flushed indices by a simultaneous allocation. It also covers the refusal of a stray acknowledge and the effect-free inputs on free slots. The bench shows these through its vector table, its directed corner cases and a long random run compared against an order-list model.

// File: rtl/shtrk_pkg.sv
`timescale 1ns/1ps
package shtrk_pkg;
   typedef enum logic [1:0] {
      PH_FREE  = 2'd0,
      PH_OFFER = 2'd1,
      PH_EXCH  = 2'd2,
      PH_DONE  = 2'd3
   } phase_e;
endpackage

// File: rtl/shtrk_slot.sv
`timescale 1ns/1ps
// One tracked request: phase and recorded go-ahead bit.
module shtrk_slot
   import shtrk_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   alloc_hit,
   input  logic   kill,
   input  logic   tgt_rdy,
   input  logic   go,
   input  logic   grant_hit,
   input  logic   retire_hit,
   output phase_e phase_o,
   output logic   go_o
);
   phase_e phase_q;
   logic   go_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_FREE;
         go_q    <= 1'b0;
      end else if (alloc_hit) begin
         // the allocation target is free or being flushed this cycle
         phase_q <= PH_OFFER;
         go_q    <= 1'b0;
      end else if (kill) begin
         phase_q <= PH_FREE;
         go_q    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_FREE: begin
               phase_q <= PH_FREE;
            end
            PH_OFFER: begin
               if (go)      go_q    <= 1'b1;
               if (tgt_rdy) phase_q <= PH_EXCH;
            end
            PH_EXCH: begin
               if (go)        go_q    <= 1'b1;
               if (grant_hit) phase_q <= PH_DONE;
            end
            PH_DONE: begin
               if (retire_hit) begin
                  phase_q <= PH_FREE;
                  go_q    <= 1'b0;
               end
            end
            default: phase_q <= PH_FREE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign go_o    = go_q;
endmodule

// File: rtl/shtrk_killnet.sv
`timescale 1ns/1ps
// Finds the oldest eligible cancel and flushes it with all younger slots.
module shtrk_killnet #(
   parameter int N_SLOTS = 8,
   localparam int IW = $clog2(N_SLOTS),
   localparam int CW = IW + 1
) (
   input  logic [IW-1:0]      head,
   input  logic [N_SLOTS-1:0] live,
   input  logic [N_SLOTS-1:0] req,
   output logic [N_SLOTS-1:0] kill,
   output logic               kill_any,
   output logic [CW-1:0]      kill_base
);
   localparam logic [CW-1:0] NONE = CW'(N_SLOTS);

   logic [IW-1:0] age [N_SLOTS];

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_age
      assign age[g] = IW'(g) - head;
   end

   always_comb begin
      kill_base = NONE;
      for (int i = 0; i < N_SLOTS; i++) begin
         if (req[i] && ({1'b0, age[i]} < kill_base)) kill_base = {1'b0, age[i]};
      end
      kill_any = (kill_base != NONE);
      for (int i = 0; i < N_SLOTS; i++) begin
         kill[i] = kill_any && live[i] && ({1'b0, age[i]} >= kill_base);
      end
   end
endmodule

// File: rtl/shtrk_ptr.sv
`timescale 1ns/1ps
// Oldest-slot pointer and live count; derives the allocation index.
module shtrk_ptr #(
   parameter int N_SLOTS = 8,
   localparam int IW = $clog2(N_SLOTS),
   localparam int CW = IW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          alloc_valid,
   input  logic          retire,
   input  logic          kill_any,
   input  logic [CW-1:0] kill_base,
   output logic [IW-1:0] head,
   output logic          alloc_ready,
   output logic          alloc_fire,
   output logic [IW-1:0] alloc_slot
);
   localparam logic [CW-1:0] FULL = CW'(N_SLOTS);

   logic [IW-1:0] head_q;
   logic [CW-1:0] count_q;
   logic [CW-1:0] base;

   assign base        = kill_any ? kill_base : count_q;
   assign alloc_ready = (count_q != FULL);
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_slot  = head_q + base[IW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_q + IW'(retire);
         count_q <= base - CW'(retire) + CW'(alloc_fire);
      end
   end

   assign head = head_q;
endmodule

// File: rtl/spec_shadow_tracker.sv
`timescale 1ns/1ps
// Ordered tracker of speculative memory requests with per-slot shadows.
module spec_shadow_tracker
   import shtrk_pkg::*;
#(
   parameter int N_SLOTS = 8,
   localparam int IW = $clog2(N_SLOTS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               alloc_valid,
   output logic               alloc_ready,
   output logic [IW-1:0]      alloc_slot,
   input  logic [N_SLOTS-1:0] tgt_ready,
   input  logic [N_SLOTS-1:0] go_ahead,
   input  logic [N_SLOTS-1:0] cancel,
   input  logic               cmpl_ack,
   output logic               grant_valid,
   output logic [IW-1:0]      grant_slot,
   output logic [N_SLOTS-1:0] shadow,
   output logic [N_SLOTS-1:0] slot_live
);
   localparam int CW = IW + 1;

   initial begin
      assert (N_SLOTS >= 2 && (N_SLOTS & (N_SLOTS - 1)) == 0)
         else $error("N_SLOTS must be a power of two and at least 2");
   end

   phase_e             phase [N_SLOTS];
   logic [N_SLOTS-1:0] go_q;
   logic [N_SLOTS-1:0] live;
   logic [N_SLOTS-1:0] grant_hit;
   logic [N_SLOTS-1:0] retire_hit;
   logic [N_SLOTS-1:0] alloc_hit;
   logic [N_SLOTS-1:0] cancel_eff;
   logic [N_SLOTS-1:0] kill;
   logic               kill_any;
   logic [CW-1:0]      kill_base;
   logic [IW-1:0]      head;
   logic               alloc_fire;
   logic               retire;

   assign grant_valid = (phase[head] == PH_EXCH) && go_q[head];
   assign grant_slot  = head;
   assign retire      = (phase[head] == PH_DONE) && cmpl_ack;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      assign live[g]       = (phase[g] != PH_FREE);
      assign grant_hit[g]  = grant_valid && (head == IW'(g));
      assign retire_hit[g] = retire && (head == IW'(g));
      assign alloc_hit[g]  = alloc_fire && (alloc_slot == IW'(g));
      // committed or being committed slots are immune to cancel
      assign cancel_eff[g] = cancel[g] && live[g] && (phase[g] != PH_DONE) && !grant_hit[g];
      assign shadow[g]     = live[g] && !((head == IW'(g)) && go_q[g]);

      shtrk_slot u_slot (
         .clk        (clk),
         .rst        (rst),
         .alloc_hit  (alloc_hit[g]),
         .kill       (kill[g]),
         .tgt_rdy    (tgt_ready[g]),
         .go         (go_ahead[g]),
         .grant_hit  (grant_hit[g]),
         .retire_hit (retire_hit[g]),
         .phase_o    (phase[g]),
         .go_o       (go_q[g])
      );
   end

   shtrk_killnet #(.N_SLOTS(N_SLOTS)) u_kill (
      .head      (head),
      .live      (live),
      .req       (cancel_eff),
      .kill      (kill),
      .kill_any  (kill_any),
      .kill_base (kill_base)
   );

   shtrk_ptr #(.N_SLOTS(N_SLOTS)) u_ptr (
      .clk         (clk),
      .rst         (rst),
      .alloc_valid (alloc_valid),
      .retire      (retire),
      .kill_any    (kill_any),
      .kill_base   (kill_base),
      .head        (head),
      .alloc_ready (alloc_ready),
      .alloc_fire  (alloc_fire),
      .alloc_slot  (alloc_slot)
   );

   assign slot_live = live;
endmodule

// File: rtl/spec_shadow_tracker_chk.sv
`timescale 1ns/1ps
module spec_shadow_tracker_chk #(
   parameter int N_SLOTS = 8,
   localparam int IW = $clog2(N_SLOTS)
) (
   input logic               clk,
   input logic               rst,
   input logic               alloc_ready,
   input logic               grant_valid,
   input logic [IW-1:0]      grant_slot,
   input logic [N_SLOTS-1:0] shadow,
   input logic [N_SLOTS-1:0] slot_live,
   input logic [IW-1:0]      head
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (slot_live == '0 && shadow == '0 && alloc_ready && !grant_valid));

   p_full_refuse_r2: assert property (@(posedge clk) disable iff (rst)
      ($countones(slot_live) == N_SLOTS) |-> !alloc_ready);

   p_single_open_r4: assert property (@(posedge clk) disable iff (rst)
      $countones(slot_live & ~shadow) <= 1);

   p_grant_unshadowed_r4: assert property (@(posedge clk) disable iff (rst)
      grant_valid |-> (slot_live[grant_slot] && !shadow[grant_slot]));

   p_grant_oldest_r5: assert property (@(posedge clk) disable iff (rst)
      grant_valid |-> (grant_slot == head));

   p_grant_once_r6: assert property (@(posedge clk) disable iff (rst)
      grant_valid |=> !grant_valid);

   p_granted_survives_r8: assert property (@(posedge clk) disable iff (rst)
      grant_valid |=> slot_live[$past(grant_slot)]);
endmodule

bind spec_shadow_tracker spec_shadow_tracker_chk #(.N_SLOTS(N_SLOTS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .alloc_ready (alloc_ready),
   .grant_valid (grant_valid),
   .grant_slot  (grant_slot),
   .shadow      (shadow),
   .slot_live   (slot_live),
   .head        (head)
);

// File: tb/spec_shadow_tracker_test.sv
`timescale 1ns/1ps
module spec_shadow_tracker_test;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         alloc_valid = 1'b0;
   logic         alloc_ready;
   logic [2:0]   alloc_slot;
   logic [N-1:0] tgt_ready = '0;
   logic [N-1:0] go_ahead = '0;
   logic [N-1:0] cancel = '0;
   logic         cmpl_ack = 1'b0;
   logic         grant_valid;
   logic [2:0]   grant_slot;
   logic [N-1:0] shadow;
   logic [N-1:0] slot_live;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   spec_shadow_tracker #(.N_SLOTS(N)) uut (
      .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_slot(alloc_slot), .tgt_ready(tgt_ready), .go_ahead(go_ahead),
      .cancel(cancel), .cmpl_ack(cmpl_ack), .grant_valid(grant_valid),
      .grant_slot(grant_slot), .shadow(shadow), .slot_live(slot_live)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   typedef struct packed {
      logic       al;
      logic [7:0] tg;
      logic [7:0] go;
      logic [7:0] cn;
      logic       ak;
      logic [7:0] live;
      logic       gv;
      logic [2:0] gs;
      logic       rdy;
      logic [3:0] req;
   } row_t;

   localparam int NROWS = 26;
   localparam logic [42:0] TBL [NROWS] = '{
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h01, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 first slot
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h03, 1'b0, 3'd0, 1'b1, 4'd2},  // R2
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h07, 1'b0, 3'd0, 1'b1, 4'd2},  // R2
      {1'b0, 8'h06, 8'h06, 8'h00, 1'b0, 8'h07, 1'b0, 3'd0, 1'b1, 4'd5},  // R5 younger ready waits
      {1'b0, 8'h00, 8'h01, 8'h00, 1'b0, 8'h07, 1'b0, 3'd0, 1'b1, 4'd3},  // R3 offer not granted
      {1'b0, 8'h01, 8'h00, 8'h00, 1'b0, 8'h07, 1'b1, 3'd0, 1'b1, 4'd5},  // R5 oldest granted
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h07, 1'b0, 3'd0, 1'b1, 4'd6},  // R6 waits for ack
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h06, 1'b1, 3'd1, 1'b1, 4'd6},  // R6 freed, next granted
      {1'b1, 8'h00, 8'h00, 8'h05, 1'b0, 8'h06, 1'b0, 3'd0, 1'b1, 4'd8},  // R8 grant cycle cancel, R9
      {1'b0, 8'h00, 8'h00, 8'h02, 1'b0, 8'h06, 1'b0, 3'd0, 1'b1, 4'd8},  // R8 done slot immune
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h04, 1'b0, 3'd0, 1'b1, 4'd6},  // R6
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0C, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 wrap fill
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h1C, 1'b0, 3'd0, 1'b1, 4'd2},
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h3C, 1'b0, 3'd0, 1'b1, 4'd2},
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h7C, 1'b0, 3'd0, 1'b1, 4'd2},
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFC, 1'b0, 3'd0, 1'b1, 4'd2},
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFD, 1'b0, 3'd0, 1'b1, 4'd2},
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd2},  // R2 full
      {1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd2},  // R2 refused
      {1'b0, 8'h00, 8'h00, 8'h40, 1'b0, 8'h3C, 1'b0, 3'd0, 1'b1, 4'd7},  // R7 younger flushed
      {1'b1, 8'h00, 8'h00, 8'h08, 1'b0, 8'h0C, 1'b0, 3'd0, 1'b1, 4'd10}, // R10 alloc reuses slot
      {1'b0, 8'h0C, 8'h0C, 8'h00, 1'b0, 8'h0C, 1'b1, 3'd2, 1'b1, 4'd5},  // R5
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0C, 1'b0, 3'd0, 1'b1, 4'd6},  // R6
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h08, 1'b1, 3'd3, 1'b1, 4'd6},  // R6
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h08, 1'b0, 3'd0, 1'b1, 4'd6},  // R6 stray ack ignored
      {1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 3'd0, 1'b1, 4'd6}   // R6
   };

   // reference order-list model
   int m_ph [N];
   bit m_go [N];
   int m_head;
   int m_cnt;

   function automatic int m_age(int i);
      return (i - m_head + N) % N;
   endfunction

   function automatic bit m_gv();
      return m_cnt != 0 && m_ph[m_head] == 2 && m_go[m_head];
   endfunction

   task automatic model_step(input bit al, input logic [N-1:0] tg, input logic [N-1:0] go,
                             input logic [N-1:0] cn, input bit ak, output int aslot);
      bit gv = m_gv();
      int amin = N;
      bit ret = (m_cnt != 0) && m_ph[m_head] == 3 && ak;
      int base;
      bit doal;
      for (int i = 0; i < N; i++)
         if (m_ph[i] != 0 && cn[i] && m_ph[i] != 3 && !(gv && i == m_head) && m_age(i) < amin)
            amin = m_age(i);
      base  = (amin < N) ? amin : m_cnt;
      doal  = al && (m_cnt < N);
      aslot = (m_head + base) % N;
      for (int i = 0; i < N; i++) begin
         if (m_ph[i] != 0 && amin < N && m_age(i) >= amin) begin
            m_ph[i] = 0; m_go[i] = 0;
         end else begin
            case (m_ph[i])
               1: begin if (go[i]) m_go[i] = 1; if (tg[i]) m_ph[i] = 2; end
               2: begin if (go[i]) m_go[i] = 1; if (gv && i == m_head) m_ph[i] = 3; end
               3: if (ret && i == m_head) begin m_ph[i] = 0; m_go[i] = 0; end
               default: ;
            endcase
         end
      end
      if (doal) begin m_ph[aslot] = 1; m_go[aslot] = 0; end
      m_cnt  = base - int'(ret) + int'(doal);
      m_head = (m_head + int'(ret)) % N;
   endtask

   initial begin
      #900000;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      row_t r;
      int aslot;
      logic [N-1:0] e_live, e_sh;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(slot_live == '0 && shadow == '0, "R1", {slot_live, shadow}, 0);
      chk(alloc_ready && !grant_valid, "R1", {alloc_ready, grant_valid}, 2);
      rst = 1'b0;

      for (int k = 0; k < NROWS; k++) begin
         r = row_t'(TBL[k]);
         alloc_valid = r.al; tgt_ready = r.tg; go_ahead = r.go; cancel = r.cn; cmpl_ack = r.ak;
         @(negedge clk);
         chk(slot_live == r.live, $sformatf("R%0d row %0d live", r.req, k), slot_live, r.live);
         chk(grant_valid == r.gv && (!r.gv || grant_slot == r.gs),
             $sformatf("R%0d row %0d grant", r.req, k), {grant_valid, grant_slot}, {r.gv, r.gs});
         chk(alloc_ready == r.rdy, $sformatf("R%0d row %0d ready", r.req, k), alloc_ready, r.rdy);
      end
      alloc_valid = 0; tgt_ready = '0; go_ahead = '0; cancel = '0; cmpl_ack = 0;

      // oldest slot is now index 4. R9: go-ahead on free slots is dropped
      go_ahead = '1; tgt_ready = '1; cancel = '1;
      @(negedge clk);
      go_ahead = '0; tgt_ready = '0; cancel = '0;
      chk(slot_live == '0, "R9 free inputs", slot_live, 0);
      alloc_valid = 1;
      #1 chk(alloc_slot == 3'd4, "R2 alloc index", alloc_slot, 4);
      @(negedge clk);
      alloc_valid = 0;
      chk(shadow == 8'h10, "R9 new slot shadowed", shadow, 8'h10);
      // R4: go-ahead lowers the oldest slot's shadow only
      alloc_valid = 1; go_ahead = 8'h10;
      @(negedge clk);
      alloc_valid = 1; go_ahead = '0;
      chk(shadow == 8'h20 && slot_live == 8'h30, "R4 shadow", {shadow, slot_live}, 16'h2030);
      @(negedge clk);
      alloc_valid = 0;
      // R10: flush everything, simultaneous alloc lands at former oldest
      cancel = 8'h10; alloc_valid = 1;
      #1 chk(alloc_slot == 3'd4, "R10 alloc after full flush", alloc_slot, 4);
      @(negedge clk);
      cancel = '0; alloc_valid = 0;
      chk(slot_live == 8'h10, "R7 full flush", slot_live, 8'h10);

      // random run against the model, after a fresh reset
      rst = 1;
      @(negedge clk);
      chk(slot_live == '0 && alloc_ready, "R1 mid-run reset", slot_live, 0);
      rst = 0;
      for (int i = 0; i < N; i++) begin m_ph[i] = 0; m_go[i] = 0; end
      m_head = 0; m_cnt = 0;
      for (int c = 0; c < 5000; c++) begin
         for (int i = 0; i < N; i++) begin
            e_live[i] = (m_ph[i] != 0);
            e_sh[i]   = e_live[i] && !(i == m_head && m_go[i]);
         end
         chk(slot_live == e_live, "R7 random live", slot_live, e_live);
         chk(shadow == e_sh, "R4 random shadow", shadow, e_sh);
         chk(grant_valid == m_gv() && (!m_gv() || grant_slot == 3'(m_head)),
             "R5 random grant", {grant_valid, grant_slot}, {m_gv(), 3'(m_head)});
         chk(alloc_ready == (m_cnt < N), "R2 random ready", alloc_ready, m_cnt < N);
         alloc_valid = ($urandom % 8) < 3;
         tgt_ready   = N'($urandom) & N'($urandom);
         go_ahead    = N'($urandom) & N'($urandom);
         cancel      = (($urandom % 12) == 0) ? N'(1 << ($urandom % N)) : '0;
         cmpl_ack    = ($urandom % 2) == 0;
         model_step(alloc_valid, tgt_ready, go_ahead, cancel, cmpl_ack, aslot);
         #1;
         if (alloc_valid && alloc_ready)
            chk(alloc_slot == 3'(aslot), "R10 random alloc index", alloc_slot, aslot);
         @(negedge clk);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule